// File: doc/BRIEF.md
# Three-Way Two's Complement Negator

This block takes one 64-bit signed operand and returns its two's complement negation three times, each computed by a different method. One path complements every bit and adds one. One path uses ordinary arithmetic negation. The third path uses no adder at all: it finds the lowest set bit of the operand, passes that bit and every bit below it through unchanged, and inverts every bit above it.

A fourth output, an agreement flag, is high when the three results are bitwise identical. Because equality does not depend on signedness, a plain bit-for-bit compare is enough. The block is purely combinational, with no clock, no registers and no handshake. It is meant as a self-checking datapath element: a host can watch the flag and catch a fault in any one of the three negation paths.

Top module: `tri_negator`

## Requirements
- R1: `neg_inv_inc` equals the bitwise complement of `operand` plus one, truncated to 64 bits.
- R2: `neg_arith` equals the arithmetic negation of `operand`, truncated to 64 bits.
- R3: For a nonzero `operand` whose lowest set bit is at index p, bits 0 through p of `neg_copy_flip` equal the same bits of `operand`, and bits p+1 through 63 are their inverses.
- R4: When `operand` is zero, all three negation outputs are zero and `agree` is high.
- R5: The most negative value, with only bit 63 set, negates to itself on all three outputs.
- R6: `agree` is high exactly when the three negation outputs are bitwise identical. For a correct design this holds for every operand.
- R7: Every output reflects a new `operand` value within the same clock cycle, with no register in any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 64 | Signed value to be negated |
| neg_inv_inc | output | 64 | Negation formed by complementing the operand and adding one |
| neg_arith | output | 64 | Negation formed by arithmetic negation |
| neg_copy_flip | output | 64 | Negation formed by copying up to the lowest set bit and inverting the bits above it |
| agree | output | 1 | High when all three negation outputs match bit for bit |

## Verification
The bench drives the operand with these cases:
- **Zero.** A copy-flip path that ignores the no-bit-set case would return a word of all ones except bit 0, instead of zero.
- **Each of the 64 single-bit values.** These find an off-by-one in the shift-built mask. Such a fault either inverts the lowest set bit itself or leaves the bit just above it uninverted.
- **Minus one, plus one, the most positive value and the most negative value.** These stress the carry chain and the top-bit edge of the mask. A mask that fails to collapse to empty at index 63 would disturb the most negative value, which must map to itself.
- **Random operands.** These mix every case together.

Each output is compared with a behavioural reference in the same cycle that the operand changes.

// File: rtl/neg_pkg.sv
package neg_pkg;
  parameter int unsigned DATA_W = 64;
  localparam int unsigned POS_W = $clog2(DATA_W);
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/lowbit_finder.sv
module lowbit_finder #(
  parameter int unsigned W = 64,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          none
);
  // Scan from the top down so the last hit is the lowest set bit.
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = PW'(i);
    end
  end

  assign none = ~|vec;

  // R3: the reported index points at a set bit, and no bit below it is set.
  always_comb begin
    if (!none) begin
      a_r3_pos_is_lowest: assert (vec[pos] && ((vec & ((W'(1) << pos) - W'(1))) == '0))
        else $error("lowbit_finder: index does not mark the lowest set bit");
    end
  end
endmodule

// File: rtl/copy_flip_negator.sv
module copy_flip_negator #(
  parameter int unsigned W = 64,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] neg
);
  logic [PW-1:0] low_pos;
  logic          is_zero;
  logic [W-1:0]  at_and_above;
  logic [W-1:0]  only_low;
  logic [W-1:0]  flip_mask;

  lowbit_finder #(.W(W)) u_find (
    .vec  (vec),
    .pos  (low_pos),
    .none (is_zero)
  );

  // The index is not a constant, so the masks are built with shifts.
  assign at_and_above = {W{1'b1}} << low_pos;
  assign only_low     = W'(1) << low_pos;
  assign flip_mask    = at_and_above ^ only_low;
  assign neg          = is_zero ? '0 : (vec ^ flip_mask);

  // R4: a zero operand must give zero.
  always_comb begin
    if (vec == '0) begin
      a_r4_zero_passes: assert (neg == '0)
        else $error("copy_flip_negator: nonzero result for zero operand");
    end
  end
endmodule

// File: rtl/tri_negator.sv
module tri_negator #(
  parameter int unsigned W = neg_pkg::DATA_W
) (
  input  logic [W-1:0] operand,
  output logic [W-1:0] neg_inv_inc,
  output logic [W-1:0] neg_arith,
  output logic [W-1:0] neg_copy_flip,
  output logic         agree
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // R1: complement, then add one.
  assign neg_inv_inc = ~operand + W'(1);

  // R2: arithmetic negation.
  assign neg_arith = -operand;

  // R3: copy the low bits, invert the high bits.
  copy_flip_negator #(.W(W)) u_copy_flip (
    .vec (operand),
    .neg (neg_copy_flip)
  );

  // R6: a bitwise compare is valid because equality ignores signedness.
  assign agree = (neg_inv_inc == neg_arith) && (neg_arith == neg_copy_flip);

  always_comb begin
    a_r1_sum_is_zero: assert ((operand + neg_inv_inc) == '0)
      else $error("tri_negator: complement-plus-one result does not cancel the operand");
    a_r2_matches_sub: assert ((W'(0) - operand) == neg_arith)
      else $error("tri_negator: arithmetic result wrong");
    a_r3_lowbits_kept: assert ((neg_copy_flip & (operand & (~operand + W'(1))))
                               == (operand & (~operand + W'(1))))
      else $error("tri_negator: lowest set bit not preserved");
    a_r6_agree_high: assert (agree)
      else $error("tri_negator: the three paths disagree");
    if (operand == MOST_NEG) begin
      a_r5_most_neg_fixed: assert (neg_copy_flip == MOST_NEG && neg_arith == MOST_NEG)
        else $error("tri_negator: most negative value not self-mapped");
    end
  end
endmodule

// File: tb/test_tri_negator.sv
module test_tri_negator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] operand = '0;
  logic [63:0] neg_inv_inc, neg_arith, neg_copy_flip;
  logic        agree;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tri_negator i_tri_negator (
    .operand       (operand),
    .neg_inv_inc   (neg_inv_inc),
    .neg_arith     (neg_arith),
    .neg_copy_flip (neg_copy_flip),
    .agree         (agree)
  );

  function automatic logic [63:0] ref_neg(input logic [63:0] x);
    longint v = longint'(x);
    return 64'(-v);
  endfunction

  function automatic logic [63:0] ref_copy(input logic [63:0] x);
    logic [63:0] r = x;
    bit seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (seen) r[i] = ~x[i];
      if (x[i]) seen = 1'b1;
    end
    return r;
  endfunction

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // The operand changes just after a rising edge, and the outputs are checked at
  // the falling edge of the same cycle (R7: no register in any path).
  task automatic apply(input logic [63:0] x);
    logic [63:0] e;
    @(posedge clk);
    #1 operand = x;
    @(negedge clk);
    e = ref_neg(x);
    check64("R1", "neg_inv_inc", neg_inv_inc, e);
    check64("R2", "neg_arith", neg_arith, e);
    check64("R3", "neg_copy_flip", neg_copy_flip, ref_copy(x));
    check64("R6", "agree", {63'b0, agree}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R4: zero operand
    @(negedge clk);
    check64("R4", "zero neg_copy_flip", neg_copy_flip, 64'd0);
    check64("R4", "zero neg_arith", neg_arith, 64'd0);
    check64("R4", "zero agree", {63'b0, agree}, 64'd1);
    apply(64'd0);
    apply(64'd1);
    apply('1);
    // R5: most negative value maps to itself
    apply(64'h8000_0000_0000_0000);
    check64("R5", "most negative copy", neg_copy_flip, 64'h8000_0000_0000_0000);
    check64("R5", "most negative inv_inc", neg_inv_inc, 64'h8000_0000_0000_0000);
    apply(64'h7FFF_FFFF_FFFF_FFFF);
    for (int p = 0; p < 64; p++) apply(64'd1 << p);
    for (int p = 0; p < 64; p++) apply(64'hA5A5_0000_0000_0000 | (64'd1 << p));
    // R7: a mid-cycle change settles without any clock edge
    @(posedge clk);
    #1 operand = 64'd12;
    #1 check64("R7", "mid-cycle update", neg_copy_flip, 64'hFFFF_FFFF_FFFF_FFF4);
    for (int k = 0; k < 300; k++) apply({$urandom(), $urandom()});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule